// File: doc/BRIEF.md
# Synchronous Burst SRAM with Strobed Address Front End

This block models a single-port synchronous SRAM together with the control logic that sits in front of its storage array. A read or write burst starts when one of two address strobes is accepted: one strobe belongs to a processor, the other to a memory controller. The accepted strobe loads the full address into an address register, and the two lowest bits of that address become a small burst counter. After that, an advance input steps the counter through the four words of an aligned group while the upper address bits stay fixed. Writes can cover the whole word through a global write input, or selected 9-bit lanes through a byte-write enable and per-lane selects.

Every control input is sampled on the rising clock edge, except the output enable, which acts on the shared data bus straight away. Read data is registered, so it appears on the bus one clock after the access that fetched it. Three chip enables must all be active for the device to be selected. When the device comes out of a deselected state, nothing is driven during the first clock of the new read. The storage depth is a parameter, so the model stays small in simulation while it keeps the full-width address port.

Top module: `burst_sram`

## Requirements
- R1: The device is selected only when ce1_n=0, ce2=1 and ce3_n=0. An accepted strobe while the device is not selected makes it idle. While idle, write inputs are ignored and no reads are issued until a strobe is accepted with the device selected.
- R2: An accepted strobe while the device is selected loads all of addr into the address register and starts an access at that address. An access started by the processor strobe (strb_cpu_n=0) is always a read, whatever the write inputs hold.
- R3: An access started by the controller strobe (strb_ctl_n=0) writes at the loaded address in that same edge if gwr_n=0 or bwr_en_n=0. When both strobes are low in the same edge with ce1_n=0, only the processor strobe acts, so no write takes place.
- R4: The processor strobe is ignored while ce1_n=1. If the controller strobe is also high, the current burst goes on unchanged.
- R5: On an edge with no accepted strobe, during a burst and with adv_n=0, the access address becomes the register value with bits [1:0] incremented modulo 4 in linear order. Bits above 1 stay unchanged. With adv_n=1 the access repeats the same address.
- R6: With gwr_n=0 on a write access, all four lanes are written, whatever bwr_en_n and bsel_n hold.
- R7: With gwr_n=1 and bwr_en_n=0, lane i (dq[9i+8:9i]) is written only if bsel_n[i]=0. With gwr_n=1 and bwr_en_n=1 the access is a read, and bsel_n has no effect.
- R8: The data of a read access is driven on dq after the next rising edge and stays there until the edge after that. Between the access edge and that next edge, dq still shows the previous read.
- R9: oe_n is asynchronous and active low. With oe_n=1, dq is not driven and serves as the write data input. A change of oe_n to 0 drives pending read data without waiting for a clock edge.
- R10: After any edge that carried no read access (idle, deselect or write), dq is not driven during the following clock, even with oe_n=0. This masks the first clock of a read that follows a deselected state.
- R11: After an asynchronous reset (rst_n=0), the device is idle: writes without an accepted strobe do not change the memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (19) | Word address, loaded on an accepted strobe |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwr_en_n | input | 1 | Lane-write enable, active low |
| bsel_n | input | LANES (4) | Per-lane write selects, active low, bit i for dq[9i+8:9i] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | DATA_W (36) | Bidirectional data bus |

## Verification
Bursts are started at each low-address phase, including 2'b10 and 2'b01, so that a linear wrap from 3 to 0 can be told apart from a carry into bit 2. Bursts that hold with adv_n high show that the counter does not drift. Lane writes use an alternating select mask, and the bench compares them with global writes that carry all selects high, which separates lane gating from the global override. Strobe tests put both strobes low with write data on the bus, and a processor strobe with ce1_n high in the middle of a burst. Each of the three chip enables is made inactive on its own, followed by a write attempt, which shows whether deselect and idle really block the memory.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // width of the in-burst address counter
  localparam int unsigned BURST_W = 2;

  // kind of array access decided on a clock edge
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned MEM_AW = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gwr_n,
  input  logic              bwr_en_n,
  input  logic [LANES-1:0]  bsel_n,
  output logic [LANES-1:0]  wr_be_o,
  output logic [MEM_AW-1:0] wr_addr_o,
  output logic              rd_vld_o,
  output logic [MEM_AW-1:0] rd_addr_o
);

  localparam int unsigned UP_W = ADDR_W - BURST_W;

  logic              sel;
  logic              cpu_ld;
  logic              ctl_ld;
  logic              ld;
  logic              wr_req;
  logic [LANES-1:0]  lane_en;
  acc_kind_e         acc_kind;
  logic [ADDR_W-1:0] acc_addr;

  logic              act_q,  act_d;
  logic [ADDR_W-1:0] ab_q,   ab_d;
  logic              ab_en;
  logic              rd_vld_q;
  logic [MEM_AW-1:0] rd_addr_q;

  // decode of strobes, selects and write inputs
  always_comb begin
    sel     = !ce1_n && ce2 && !ce3_n;
    cpu_ld  = !strb_cpu_n && !ce1_n;
    ctl_ld  = !strb_ctl_n && !cpu_ld;
    ld      = cpu_ld || ctl_ld;
    wr_req  = !gwr_n || !bwr_en_n;
    if (!gwr_n)         lane_en = '1;
    else if (!bwr_en_n) lane_en = ~bsel_n;
    else                lane_en = '0;
  end

  // next-state logic
  always_comb begin
    act_d    = act_q;
    ab_d     = ab_q;
    ab_en    = 1'b0;
    acc_kind = ACC_NONE;
    acc_addr = ab_q;
    if (ld) begin
      if (sel) begin
        act_d    = 1'b1;
        ab_d     = addr;
        ab_en    = 1'b1;
        acc_addr = addr;
        acc_kind = (ctl_ld && wr_req) ? ACC_WRITE : ACC_READ;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      if (!adv_n) begin
        acc_addr = {ab_q[ADDR_W-1:BURST_W], ab_q[BURST_W-1:0] + {{(BURST_W-1){1'b0}}, 1'b1}};
      end
      ab_d     = acc_addr;
      ab_en    = !adv_n;
      acc_kind = wr_req ? ACC_WRITE : ACC_READ;
    end
  end

  always_comb begin
    wr_be_o   = (acc_kind == ACC_WRITE) ? lane_en : '0;
    wr_addr_o = acc_addr[MEM_AW-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      rd_vld_q <= 1'b0;
    end else begin
      act_q    <= act_d;
      rd_vld_q <= (acc_kind == ACC_READ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q <= '0;
    end else if (ab_en) begin
      ab_q <= ab_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
    end else if (acc_kind == ACC_READ) begin
      rd_addr_q <= acc_addr[MEM_AW-1:0];
    end
  end

  assign rd_vld_o  = rd_vld_q;
  assign rd_addr_o = rd_addr_q;

  // R4: processor strobe with ce1_n high leaves burst state alone
  a_r4_ce1_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && ce1_n && strb_ctl_n && adv_n) |=> ($stable(ab_q) && $stable(act_q)));

  // R3: both strobes low with ce1_n low never writes
  a_r3_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !strb_ctl_n && !ce1_n) |-> (wr_be_o == '0));

  // R5: linear wrap of the burst counter
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && (strb_cpu_n || ce1_n) && strb_ctl_n && !adv_n && (ab_q[BURST_W-1:0] == '1))
      |=> (ab_q[BURST_W-1:0] == '0));

  // R5: upper bits fixed while no strobe is accepted
  a_r5_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_cpu_n || ce1_n) && strb_ctl_n) |=> $stable(ab_q[ADDR_W-1:BURST_W]));

  // R1: idle device issues neither writes nor reads
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && (strb_cpu_n || ce1_n) && strb_ctl_n) |=> !rd_vld_q);

  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && (strb_cpu_n || ce1_n) && strb_ctl_n) |-> (wr_be_o == '0));

  // R6: global write covers every lane during a burst write
  a_r6_global_all: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && (strb_cpu_n || ce1_n) && strb_ctl_n && !gwr_n) |-> (wr_be_o == '1));

  logic [UP_W-1:0] unused_up;
  assign unused_up = '0;

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int unsigned MEM_AW = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [MEM_AW-1:0]       wr_addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    rd_en_i,
  input  logic [MEM_AW-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << MEM_AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_be_i[g]) begin
        mem[wr_addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en_i) begin
        rd_q <= mem[rd_addr_i];
      end
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/burst_sram_io.sv
module burst_sram_io (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_vld_i,
  input  logic oe_n,
  output logic dq_oe_o
);

  logic dout_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_vld_q <= 1'b0;
    end else begin
      dout_vld_q <= rd_vld_i;
    end
  end

  // asynchronous gate: oe_n acts without a clock edge
  assign dq_oe_o = !oe_n && dout_vld_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned MEM_AW = 6,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gwr_n,
  input  logic              bwr_en_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              oe_n,
  inout  wire  [DATA_W-1:0] dq
);

  logic [LANES-1:0]  wr_be;
  logic [MEM_AW-1:0] wr_addr;
  logic              rd_vld;
  logic [MEM_AW-1:0] rd_addr;
  logic [DATA_W-1:0] rdata;
  logic              dq_oe;

  burst_sram_ctrl #(
    .ADDR_W (ADDR_W),
    .MEM_AW (MEM_AW),
    .LANES  (LANES)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .gwr_n      (gwr_n),
    .bwr_en_n   (bwr_en_n),
    .bsel_n     (bsel_n),
    .wr_be_o    (wr_be),
    .wr_addr_o  (wr_addr),
    .rd_vld_o   (rd_vld),
    .rd_addr_o  (rd_addr)
  );

  burst_sram_array #(
    .MEM_AW (MEM_AW),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) array_i (
    .clk       (clk),
    .wr_be_i   (wr_be),
    .wr_addr_i (wr_addr),
    .wdata_i   (dq),
    .rd_en_i   (rd_vld),
    .rd_addr_i (rd_addr),
    .rdata_o   (rdata)
  );

  burst_sram_io io_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_vld_i (rd_vld),
    .oe_n     (oe_n),
    .dq_oe_o  (dq_oe)
  );

  assign dq = dq_oe ? rdata : {DATA_W{1'bz}};

  // R10: an edge without a read access leaves the bus undriven for a clock
  a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |=> !dq_oe);

  // R9: bus never driven while output enable is high
  always_comb begin
    if (rst_n && oe_n) begin
      a_r9_oe_off: assert (!dq_oe);
    end
  end

endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

  localparam int unsigned AW = 19;
  localparam int unsigned DW = 36;
  localparam int unsigned MAW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          strb_cpu_n, strb_ctl_n, adv_n;
  logic          ce1_n, ce2, ce3_n;
  logic          gwr_n, bwr_en_n;
  logic [3:0]    bsel_n;
  logic          oe_n;
  logic          tb_en;
  logic [DW-1:0] tb_d;
  wire  [DW-1:0] dq;

  logic [DW-1:0] ref_mem [1<<MAW];
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  assign dq = tb_en ? tb_d : {DW{1'bz}};

  burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(9), .MEM_AW(MAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .gwr_n(gwr_n), .bwr_en_n(bwr_en_n), .bsel_n(bsel_n),
    .oe_n(oe_n), .dq(dq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gwr_n = 1'b1; bwr_en_n = 1'b1; bsel_n = 4'hF;
    oe_n = 1'b0; tb_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // controller-strobe load that writes the whole word at the loaded address
  task automatic wr_word(input int a, input logic [DW-1:0] d);
    idle(); oe_n = 1'b1;
    strb_ctl_n = 1'b0; addr = AW'(a); gwr_n = 1'b0;
    tb_en = 1'b1; tb_d = d;
    tick();
    ref_mem[a] = d;
    idle();
  endtask

  // processor-strobe read, data checked one edge later
  task automatic rd_chk(input int a, input string tag);
    idle();
    strb_cpu_n = 1'b0; addr = AW'(a);
    tick();
    idle();
    tick();
    chk(tag, dq, ref_mem[a]);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) wr_word(i, {4'h0, 32'hA5000000 + 32'(i * 32'h01010101)});
    for (int i = 0; i < 16; i++) rd_chk(i, "R3 R2 fill readback");
  endtask

  task automatic t_reset();
    idle(); rst_n = 1'b0;
    tick(); rst_n = 1'b1;
    // idle after reset: write without strobe must not land at address 0
    oe_n = 1'b1; gwr_n = 1'b0; tb_en = 1'b1; tb_d = 36'hBADBADBAD;
    tick(); tick();
    idle();
    rd_chk(0, "R11 reset idle blocks write");
  endtask

  task automatic t_burst_write();
    logic [DW-1:0] d;
    idle(); oe_n = 1'b1;
    strb_cpu_n = 1'b0; addr = AW'(38);          // low bits 2'b10
    tick();
    idle(); oe_n = 1'b1; gwr_n = 1'b0; tb_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      adv_n = (k == 0);
      d = 36'h100000000 + 36'(k);
      tb_d = d;
      tick();
      ref_mem[36 + ((2 + k) % 4)] = d;       // 38,39,36,37: R5 wrap
    end
    idle();
    for (int j = 36; j < 40; j++) rd_chk(j, "R5 burst write wrap");
    rd_chk(40, "R5 upper bits fixed");
  endtask

  task automatic t_burst_read();
    wr_word(4, 36'h0_4444_4444); wr_word(5, 36'h0_5555_5555);
    wr_word(6, 36'h0_6666_6666); wr_word(7, 36'h0_7777_7777);
    idle(); strb_cpu_n = 1'b0; addr = AW'(5);
    tick();
    idle(); adv_n = 1'b0;
    tick(); chk("R8 R5 read 5", dq, ref_mem[5]);
    tick(); chk("R5 read 6", dq, ref_mem[6]);
    tick(); chk("R5 read 7", dq, ref_mem[7]);
    adv_n = 1'b1;
    tick(); chk("R5 wrap read 4", dq, ref_mem[4]);
    tick(); chk("R5 hold read 4", dq, ref_mem[4]);
  endtask

  task automatic t_pipe();
    idle(); strb_cpu_n = 1'b0; addr = AW'(2);
    tick(); idle(); tick();
    strb_cpu_n = 1'b0; addr = AW'(9);
    tick();
    chk("R8 old data during access clock", dq, ref_mem[2]);
    idle();
    tick();
    chk("R8 new data after next edge", dq, ref_mem[9]);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] d;
    wr_word(20, 36'h123456789);
    d = 36'hFEDCBA987;
    idle(); oe_n = 1'b1; strb_ctl_n = 1'b0; addr = AW'(20);
    bwr_en_n = 1'b0; bsel_n = 4'b1010; tb_en = 1'b1; tb_d = d;
    tick();
    ref_mem[20][8:0]   = d[8:0];
    ref_mem[20][26:18] = d[26:18];
    idle();
    rd_chk(20, "R7 lanes 0 and 2 only");
    d = 36'h0DEADBEEF;
    idle(); oe_n = 1'b1; strb_ctl_n = 1'b0; addr = AW'(20);
    gwr_n = 1'b0; bwr_en_n = 1'b0; bsel_n = 4'hF; tb_en = 1'b1; tb_d = d;
    tick();
    ref_mem[20] = d;
    idle();
    rd_chk(20, "R6 global overrides lane selects");
    idle(); oe_n = 1'b1; strb_ctl_n = 1'b0; addr = AW'(20);
    bsel_n = 4'h0; tb_en = 1'b1; tb_d = 36'h111111111;
    tick();
    idle();
    rd_chk(20, "R7 selects without enable do nothing");
  endtask

  task automatic t_prio();
    idle(); oe_n = 1'b1;
    strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; addr = AW'(10);
    gwr_n = 1'b0; tb_en = 1'b1; tb_d = 36'hCCCCCCCCC;
    tick();
    idle();
    tick();
    chk("R3 processor strobe wins, read issued", dq, ref_mem[10]);
    rd_chk(10, "R3 no write on dual strobe");
  endtask

  task automatic t_ce1();
    idle(); strb_cpu_n = 1'b0; addr = AW'(1);
    tick();
    idle(); strb_cpu_n = 1'b0; ce1_n = 1'b1; addr = AW'(2);
    tick();
    chk("R4 burst continues", dq, ref_mem[1]);
    idle();
    tick();
    chk("R4 strobe ignored, no load", dq, ref_mem[1]);
  endtask

  task automatic t_desel();
    for (int v = 0; v < 3; v++) begin
      idle(); oe_n = 1'b1; strb_ctl_n = 1'b0; addr = AW'(3);
      gwr_n = 1'b0; tb_en = 1'b1; tb_d = 36'hEEEEEEEE0 + 36'(v);
      if (v == 0) ce1_n = 1'b1;
      if (v == 1) ce2 = 1'b0;
      if (v == 2) ce3_n = 1'b1;
      tick();
      // idle now: a write without strobe must also be dropped
      strb_ctl_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
      tick();
      idle();
      // R10: read after deselect; data valid after the masked first clock
      rd_chk(3, "R1 R10 deselect blocks write");
    end
  endtask

  task automatic t_oe();
    idle(); oe_n = 1'b1; strb_cpu_n = 1'b0; addr = AW'(7);
    tick();
    idle(); oe_n = 1'b1;
    tick();
    #2 oe_n = 1'b0;
    #1 chk("R9 async output enable", dq, ref_mem[7]);
    idle();
  endtask

  initial begin
    idle(); addr = '0; tb_d = '0; rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_fill();
    t_reset();
    t_burst_write();
    t_burst_read();
    t_pipe();
    t_lanes();
    t_prio();
    t_ce1();
    t_desel();
    t_oe();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule